// File: doc/BRIEF.md
# Row-Column Block Interleaver with Column Permutation

This block reorders a stream of channel-coded bits so that burst errors on the channel are spread over the coded block. A block of bits is written into an on-chip bit matrix one row at a time. It is then read back one column at a time, and the columns are visited in a permuted order. The number of columns and the column order depend on a transmission-interval select that is captured when the block starts.

A block starts with a start-of-block pulse that carries the first bit together with the block length and the interval select. The following valid bits fill the matrix in row-major order, and gaps in the valid strobe are allowed. Once the last bit is in, the block reads the matrix out with no further input. The unfilled tail of the last row is skipped on readout, so each block emits exactly as many bits as it received. The block handles one block at a time. A busy flag covers the whole fill and readout, and a new block can only begin once that flag is low.

Top module: `bil_interleaver`

## Requirements
- R1: After reset `busy` and `out_valid` are low.
- R2: Only cycles with `in_valid` high store a bit. The first bit is stored in the start cycle and the rest follow in arrival order. Bit number i goes to row i / C and column i mod C, where C is the column count. Gaps in `in_valid` during the fill do not change the order.
- R3: The column count C and the column read order follow `tti_sel`: 0 gives C=1 with order {0}; 1 gives C=2 with {0,1}; 2 gives C=4 with {0,2,1,3}; 3 gives C=8 with {0,4,2,6,1,5,3,7}. Each order is the bit-reversal of the visit index. Inside a column, rows are read top to bottom.
- R4: The matrix has ceil(L / C) rows, where L is the block length. Positions at row-major index L or higher are skipped, so exactly L bits leave with `out_valid` high.
- R5: `tti_sel` and `blk_len` are sampled only in the start cycle. Changing them later in the block has no effect on its output.
- R6: `busy` is high from the cycle after the start cycle until the readout scan ends. `out_valid` is high only in the cycle after a read-phase position is scanned, and so only while `busy` is high.
- R7: While `busy` is high, `sob` and `in_valid` during readout are refused. No bit is stored and no new block begins.
- R8: A start with `blk_len` equal to 0 or greater than MAX_LEN is refused, and `busy` stays low.
- R9: `in_valid` without `sob` while idle stores nothing and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sob | input | 1 | Start-of-block strobe, qualified by in_valid |
| tti_sel | input | 2 | Interval select: 0=1 col, 1=2 cols, 2=4 cols, 3=8 cols |
| blk_len | input | LEN_W ($clog2(MAX_LEN+1)) | Block length in bits, sampled at start |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Input data bit |
| out_valid | output | 1 | Output bit qualifier |
| out_bit | output | 1 | Interleaved output bit |
| busy | output | 1 | Block in progress; new blocks refused |

## Verification
The hardest case to reach from the ports is a padded position at the end of a permuted column scan. That needs a length that is not a multiple of the column count, combined with every column order, and only a full sweep over lengths reaches every pad pattern. The bench therefore runs every length from 1 to MAX_LEN under all four selects. Every block also changes `tti_sel` and `blk_len` right after the start cycle, holds `sob` and `in_valid` high through the whole readout, and on alternate blocks inserts idle gaps into the fill.

// File: rtl/bil_pkg.sv
package bil_pkg;
   localparam int unsigned TTI_W       = 2;
   localparam int unsigned COL_LOG_MAX = (1 << TTI_W) - 1;
   localparam int unsigned MAX_COLS    = 1 << COL_LOG_MAX;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_DRAIN = 2'd2
   } phase_e;
endpackage

// File: rtl/bil_mem.sv
module bil_mem #(
   parameter int unsigned DATA_W = 1,
   parameter int unsigned ADDR_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bil_mem: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= cells[raddr];
   end
endmodule

// File: rtl/bil_colperm.sv
module bil_colperm #(
   parameter int unsigned CW = 3,
   parameter int unsigned MW = 2
) (
   input  logic [CW-1:0] k,
   input  logic [MW-1:0] m,
   output logic [CW-1:0] col
);
   generate
      if (CW != (1 << MW) - 1) begin : g_bad_cfg
         $error("bil_colperm: CW must equal 2**MW - 1");
      end
   endgenerate

   logic [CW-1:0] rev;

   generate
      for (genvar b = 0; b < CW; b++) begin : g_rev
         assign rev[b] = k[CW-1-b];
      end
   endgenerate

   // reversing all CW bits then dropping the unused low part
   // gives the reversal over the m active bits
   always_comb begin
      col = rev >> (CW - int'(m));
   end
endmodule

// File: rtl/bil_wr_seq.sv
module bil_wr_seq #(
   parameter int unsigned ROW_W = 6,
   parameter int unsigned CW    = 3,
   parameter int unsigned MW    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                step,
   input  logic [MW-1:0]       m_start,
   input  logic [MW-1:0]       m_run,
   output logic [ROW_W+CW-1:0] waddr
);
   logic [ROW_W-1:0] row_q;
   logic [CW-1:0]    col_q;
   logic [CW-1:0]    col_lim;

   always_comb begin
      col_lim = CW'((32'd1 << m_run) - 32'd1);
      waddr   = start ? '0 : {row_q, col_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (start) begin
         // position 0 is written in the start cycle; point at position 1
         if (m_start == '0) begin
            row_q <= ROW_W'(1);
            col_q <= '0;
         end else begin
            row_q <= '0;
            col_q <= CW'(1);
         end
      end else if (step) begin
         if (col_q == col_lim) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   assert_col_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (col_q <= col_lim));
endmodule

// File: rtl/bil_rd_seq.sv
module bil_rd_seq #(
   parameter int unsigned LEN_W = 7,
   parameter int unsigned ROW_W = 6,
   parameter int unsigned CW    = 3,
   parameter int unsigned MW    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [MW-1:0]       m,
   input  logic [LEN_W-1:0]    len,
   input  logic [LEN_W-1:0]    rows,
   output logic [ROW_W+CW-1:0] raddr,
   output logic                pad,
   output logic                last
);
   logic [LEN_W-1:0]    rr_q;
   logic [CW-1:0]       rk_q;
   logic [CW-1:0]       col;
   logic [CW-1:0]       k_lim;
   logic [LEN_W+CW-1:0] lin_idx;
   logic                row_end;

   bil_colperm #(.CW(CW), .MW(MW)) u_perm (
      .k   (rk_q),
      .m   (m),
      .col (col)
   );

   always_comb begin
      k_lim   = CW'((32'd1 << m) - 32'd1);
      lin_idx = ({{CW{1'b0}}, rr_q} << m) + {{LEN_W{1'b0}}, col};
      pad     = lin_idx >= {{CW{1'b0}}, len};
      row_end = rr_q == (rows - 1'b1);
      last    = row_end && (rk_q == k_lim);
      raddr   = {rr_q[ROW_W-1:0], col};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         rr_q <= '0;
         rk_q <= '0;
      end else if (step) begin
         if (row_end) begin
            rr_q <= '0;
            rk_q <= rk_q + 1'b1;
         end else begin
            rr_q <= rr_q + 1'b1;
         end
      end
   end

   assert_visit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ((rk_q <= k_lim) && (rr_q < rows)));
endmodule

// File: rtl/bil_interleaver.sv
module bil_interleaver
   import bil_pkg::*;
#(
   parameter int unsigned MAX_LEN = 64,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sob,
   input  logic [1:0]       tti_sel,
   input  logic [LEN_W-1:0] blk_len,
   input  logic             in_valid,
   input  logic             in_bit,
   output logic             out_valid,
   output logic             out_bit,
   output logic             busy
);
   localparam int unsigned CW     = COL_LOG_MAX;
   localparam int unsigned ROW_W  = $clog2(MAX_LEN);
   localparam int unsigned ADDR_W = ROW_W + CW;

   generate
      if (MAX_LEN < 2) begin : g_bad_len
         $error("bil_interleaver: MAX_LEN must be at least 2");
      end
      if (TTI_W != 2) begin : g_bad_tti
         $error("bil_interleaver: select width must be 2");
      end
   endgenerate

   phase_e             state_q;
   logic [TTI_W-1:0]   m_q;
   logic [LEN_W-1:0]   len_q;
   logic [LEN_W-1:0]   rows_q;
   logic [LEN_W-1:0]   wcnt_q;
   logic               out_valid_q;

   logic               len_ok;
   logic               start;
   logic               fill_wr;
   logic               drain;
   logic               mem_we;
   logic               rd_pad;
   logic               rd_last;
   logic [ADDR_W-1:0]  waddr;
   logic [ADDR_W-1:0]  raddr;
   logic [LEN_W+CW-1:0] rows_wide;

   always_comb begin
      len_ok    = (blk_len != '0) && (blk_len <= LEN_W'(MAX_LEN));
      start     = (state_q == ST_IDLE) && !out_valid_q && sob && in_valid && len_ok;
      fill_wr   = (state_q == ST_FILL) && in_valid;
      drain     = (state_q == ST_DRAIN);
      mem_we    = start || fill_wr;
      rows_wide = ({{CW{1'b0}}, blk_len} + (LEN_W+CW)'((32'd1 << tti_sel) - 32'd1))
                  >> tti_sel;
   end

   bil_wr_seq #(.ROW_W(ROW_W), .CW(CW), .MW(TTI_W)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .step    (fill_wr),
      .m_start (tti_sel),
      .m_run   (m_q),
      .waddr   (waddr)
   );

   bil_rd_seq #(.LEN_W(LEN_W), .ROW_W(ROW_W), .CW(CW), .MW(TTI_W)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .step  (drain),
      .m     (m_q),
      .len   (len_q),
      .rows  (rows_q),
      .raddr (raddr),
      .pad   (rd_pad),
      .last  (rd_last)
   );

   bil_mem #(.DATA_W(1), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (waddr),
      .wdata (in_bit),
      .re    (drain && !rd_pad),
      .raddr (raddr),
      .rdata (out_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         m_q         <= '0;
         len_q       <= '0;
         rows_q      <= '0;
         wcnt_q      <= '0;
         out_valid_q <= 1'b0;
      end else begin
         out_valid_q <= drain && !rd_pad;
         if (start) begin
            m_q     <= tti_sel;
            len_q   <= blk_len;
            rows_q  <= rows_wide[LEN_W-1:0];
            wcnt_q  <= LEN_W'(1);
            state_q <= (blk_len == LEN_W'(1)) ? ST_DRAIN : ST_FILL;
         end else if (fill_wr) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_q == len_q - 1'b1) state_q <= ST_DRAIN;
         end else if (drain && rd_last) begin
            state_q <= ST_IDLE;
         end
      end
   end

   always_comb begin
      out_valid = out_valid_q;
      busy      = (state_q != ST_IDLE) || out_valid_q;
   end

   // checking-only count of bits emitted in the current block
   logic [LEN_W-1:0] emit_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n || start) emit_cnt_q <= '0;
      else if (out_valid_q) emit_cnt_q <= emit_cnt_q + 1'b1;
   end

   assert_no_extra_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_q |-> (emit_cnt_q < len_q));

   assert_cfg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |->
         ($stable(m_q) && $stable(len_q) && $stable(rows_q)));

   assert_out_after_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_q |-> ($past(state_q) == ST_DRAIN));

   assert_no_write_in_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN) |-> !mem_we);

   assert_bad_len_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && !out_valid_q && sob && in_valid &&
       ((blk_len == '0) || (blk_len > LEN_W'(MAX_LEN)))) |=> !busy);
endmodule

// File: tb/bil_interleaver_test.sv
`timescale 1ns/1ps
module bil_interleaver_test;
   localparam int MAX_LEN = 64;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sob = 1'b0;
   logic [1:0]       tti_sel = 2'd0;
   logic [LEN_W-1:0] blk_len = '0;
   logic             in_valid = 1'b0;
   logic             in_bit = 1'b0;
   logic             out_valid;
   logic             out_bit;
   logic             busy;

   always #4 clk = ~clk;

   bil_interleaver #(.MAX_LEN(MAX_LEN)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sob       (sob),
      .tti_sel   (tti_sel),
      .blk_len   (blk_len),
      .in_valid  (in_valid),
      .in_bit    (in_bit),
      .out_valid (out_valid),
      .out_bit   (out_bit),
      .busy      (busy)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit got [256];
   int tot_n = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         got[tot_n % 256] = out_bit;
         tot_n++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic run_block(input int tti, input int len, input int blk, input bit gap);
      bit d [MAX_LEN];
      int base, cols, rows, n, bad, j, guard;
      for (int i = 0; i < MAX_LEN; i++) d[i] = (((i * 5) + (blk * 3) + (i >> 3)) % 3) == 0;
      base = tot_n;
      sob = 1'b1; in_valid = 1'b1; tti_sel = 2'(tti); blk_len = LEN_W'(len); in_bit = d[0];
      tick();
      // R5: disturb the sampled configuration right after the start cycle
      sob = 1'b0; tti_sel = 2'(~tti); blk_len = LEN_W'(len ^ 5);
      check(busy == 1'b1, "R6 busy after start", int'(busy), 1);
      for (int i = 1; i < len; i++) begin
         if (gap && (i % 3 == 0)) begin
            in_valid = 1'b0; in_bit = ~d[i];
            tick();
         end
         in_valid = 1'b1; in_bit = d[i];
         tick();
      end
      // R7: hammer start and data during readout
      sob = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
      guard = 0;
      while (busy && guard < 400) begin
         tick();
         guard++;
      end
      sob = 1'b0; in_valid = 1'b0;
      tick();
      check(busy == 1'b0, "R7 no block started during readout", int'(busy), 0);
      n = tot_n - base;
      check(n == len, "R4 output count equals length", n, len);
      cols = 1 << tti;
      rows = (len + cols - 1) / cols;
      j = 0; bad = 0;
      for (int k = 0; k < cols; k++) begin
         int c = 0;
         for (int b = 0; b < tti; b++) if (((k >> b) & 1) != 0) c |= 1 << (tti - 1 - b);
         for (int r = 0; r < rows; r++) begin
            int idx = r * cols + c;
            if (idx < len) begin
               if (j >= n || got[(base + j) % 256] != d[idx]) bad++;
               j++;
            end
         end
      end
      if (tti == 0) check(bad == 0, "R2 R5 row-major order mismatches", bad, 0);
      else          check(bad == 0, "R3 R5 permuted column order mismatches", bad, 0);
   endtask

   initial begin
      int blk;
      repeat (5) tick();
      check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      tick();
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

      // R9: data without start strobe while idle
      in_valid = 1'b1; blk_len = LEN_W'(8); in_bit = 1'b1;
      repeat (4) tick();
      in_valid = 1'b0;
      check(busy == 1'b0, "R9 idle data ignored", int'(busy), 0);
      tick();
      check(out_valid == 1'b0, "R9 no output from idle data", int'(out_valid), 0);

      // R8: illegal lengths
      sob = 1'b1; in_valid = 1'b1; blk_len = '0;
      tick();
      sob = 1'b0; in_valid = 1'b0;
      check(busy == 1'b0, "R8 zero length refused", int'(busy), 0);
      sob = 1'b1; in_valid = 1'b1; blk_len = LEN_W'(MAX_LEN + 1);
      tick();
      sob = 1'b0; in_valid = 1'b0;
      check(busy == 1'b0, "R8 oversize length refused", int'(busy), 0);
      tick();
      check(out_valid == 1'b0, "R8 no output after refused start", int'(out_valid), 0);

      blk = 0;
      for (int t = 0; t < 4; t++) begin
         for (int len = 1; len <= MAX_LEN; len++) begin
            run_block(t, len, blk, (blk % 2) == 1);
            blk++;
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule